// File: doc/BRIEF.md
# Diskette Controller Host Command Sequencer

This block is the host-facing protocol engine of a floppy-disk controller. Software talks to it through a byte-wide register window with two live locations: a main status register (offset 4) that is polled for flow control, and a data register (offset 5) that carries command bytes in and result bytes out. Every access to offset 5 is gated by the status flags. The host waits for the ready flag, transfers one byte, and polls again. There is no valid/ready handshake on the bus, because the polled flags play that role. A byte offered while the flags say "not ready" is dropped.

A command starts with an opcode byte and continues with parameter bytes. A fixed table gives the byte and result counts for each opcode. After the final command byte the block executes the command. For a data-read command it moves bytes over a request / active-low acknowledge DMA handshake, and a drive stand-in then waits a programmable number of cycles. The block then offers result bytes one per read. A command with no results goes straight back to accepting an opcode.

Top module: `dsk_host_seq`

## Requirements
- R1: After reset the status register reads 80h (ready set; direction, no-DMA-execution and busy clear), `dma_req` is 0 and `proto_err` is 0.
- R2: Phases run only idle → command collection → execution → result → idle (results skipped when the command has none). Execution starts at the clock edge that accepts the last command byte. When the result phase opens, the status register reads D0h.
- R3: Status bit 7 (ready) is 0 for exactly the one cycle after any accepted data-register byte, written or read. Bit 6 (direction) is 0 while collecting command bytes and 1 while results are offered. Bit 4 (busy) is 1 whenever a command is underway.
- R4: Command table by full opcode byte. 03h (set-timing) takes 3 bytes and gives 0 results. 08h (interrupt-status) takes 1 byte and gives 2 results. 06h (read) takes 9 bytes and gives 7 results.
- R5: Results of 08h are 20h, then the cylinder byte (byte 2) of the most recent completed 06h command (00h after reset). Results of 06h are {00000b, byte1[2:0]}, 00h, 00h, then bytes 2, 3, 4 and 5 in that order.
- R6: Any other opcode is a one-byte command that yields exactly one result, 80h.
- R7: A command with no results ends with the status register reading 80h. A new opcode is accepted right away.
- R8: For non-DMA commands, status bit 5 is 1 for exactly D+1 cycles. D is byte 1 of the most recent 03h command, taking effect from that command's own execution, and 4 after reset. For 06h, bit 5 stays 0.
- R9: For 06h, byte 8 gives the transfer length L. `dma_req` rises, and stays high until `dma_ack_n` is sampled low. Each acknowledge moves one byte, with `dma_data` equal to 0, 1, … L-1 in order. `dma_req` is low the cycle after an acknowledge and rises again only after `dma_ack_n` returns high. L = 0 makes no request. `dma_req` is never high outside execution.
- R10: A data-register write during execution, during the result phase, or in the not-ready cycle is ignored. It does not change the command bytes or the results, and it sets `proto_err`, which then stays set until reset.
- R11: A data-register read outside the result phase returns 00h and changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 3 | Register offset (4 = status, 5 = data) |
| bus_wr | input | 1 | Write strobe, one cycle per byte |
| bus_rd | input | 1 | Read strobe; a data read in the result phase consumes a byte |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from the address |
| dma_req | output | 1 | DMA request |
| dma_ack_n | input | 1 | DMA acknowledge, active low |
| dma_data | output | 8 | Byte being transferred while acknowledged |
| proto_err | output | 1 | Sticky protocol-violation flag |

## Verification
A corrupted byte index or phase register shows up at the ports within one command. The host either sees the wrong number of ready cycles with direction set, or sees result bytes that do not match the parameters it wrote. Either shows on the next data read. A stuck not-ready flag blocks the next poll at once. A delay counter that is off by one changes the measured length of the no-DMA-execution window. A broken handshake shows as a `dma_req` that stays high after an acknowledge, or as a byte count different from the length parameter when execution ends.

// File: rtl/dsk_pkg.sv
package dsk_pkg;
  typedef enum logic [1:0] {PH_IDLE, PH_CMD, PH_EXEC, PH_RES} phase_t;

  localparam logic [7:0] OP_SET_TIMING = 8'h03;
  localparam logic [7:0] OP_READ       = 8'h06;
  localparam logic [7:0] OP_INT_STATUS = 8'h08;
  localparam logic [7:0] RES_BAD_OP    = 8'h80;
  localparam logic [7:0] INT_ST0       = 8'h20;

  localparam int MSR_RDY  = 7;
  localparam int MSR_DIR  = 6;
  localparam int MSR_NDMA = 5;
  localparam int MSR_BUSY = 4;

  localparam logic [2:0] ADDR_STATUS = 3'd4;
  localparam logic [2:0] ADDR_DATA   = 3'd5;
endpackage

// File: rtl/dsk_cmd_table.sv
module dsk_cmd_table
  import dsk_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic [7:0]       opc,
  output logic [CNT_W-1:0] n_bytes,
  output logic [CNT_W-1:0] n_res,
  output logic             dma_cmd
);
  always_comb begin
    dma_cmd = 1'b0;
    unique case (opc)
      OP_SET_TIMING: begin n_bytes = CNT_W'(3); n_res = CNT_W'(0); end
      OP_INT_STATUS: begin n_bytes = CNT_W'(1); n_res = CNT_W'(2); end
      OP_READ: begin
        n_bytes = CNT_W'(9);
        n_res   = CNT_W'(7);
        dma_cmd = 1'b1;
      end
      default: begin n_bytes = CNT_W'(1); n_res = CNT_W'(1); end
    endcase
  end
endmodule

// File: rtl/dsk_drive_stub.sv
module dsk_drive_stub #(
  parameter int DLY_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [DLY_W-1:0] dly,
  output logic             done
);
  logic             run_q;
  logic [DLY_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      cnt_q <= '0;
    end else if (start) begin
      run_q <= 1'b1;
      cnt_q <= dly;
    end else if (run_q) begin
      if (cnt_q == '0) run_q <= 1'b0;
      else             cnt_q <= cnt_q - 1'b1;
    end
  end

  assign done = run_q && (cnt_q == '0);

  // R8: a finished wait does not linger into the next cycle
  assert_stub_stops_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> !done);
endmodule

// File: rtl/dsk_dma_engine.sv
module dsk_dma_engine #(
  parameter int LEN_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go,
  input  logic [LEN_W-1:0] len,
  input  logic             dma_ack_n,
  output logic             dma_req,
  output logic [LEN_W-1:0] dma_data,
  output logic             done
);
  typedef enum logic [1:0] {D_IDLE, D_REQ, D_REL} dstate_t;
  dstate_t          st_q;
  logic [LEN_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= D_IDLE;
      cnt_q <= '0;
    end else begin
      unique case (st_q)
        D_IDLE: if (go) st_q <= D_REQ;
        D_REQ: if (!dma_ack_n) begin
          cnt_q <= cnt_q + 1'b1;
          st_q  <= D_REL;
        end
        D_REL: if (dma_ack_n) begin
          if (cnt_q == len) begin
            st_q  <= D_IDLE;
            cnt_q <= '0;
          end else begin
            st_q <= D_REQ;
          end
        end
        default: st_q <= D_IDLE;
      endcase
    end
  end

  assign dma_req  = (st_q == D_REQ);
  assign dma_data = cnt_q;
  assign done     = (st_q == D_REL) && dma_ack_n && (cnt_q == len);

  // R9: request drops right after an acknowledged byte
  assert_req_drops_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_req && !dma_ack_n) |=> !dma_req);
  // R9: request held until the acknowledge arrives
  assert_req_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_req && dma_ack_n) |=> dma_req);
endmodule

// File: rtl/dsk_host_seq.sv
module dsk_host_seq
  import dsk_pkg::*;
#(
  parameter int DW        = 8,
  parameter int DLY_W     = 8,
  parameter int DEF_DELAY = 4,
  parameter int MAX_BYTES = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [2:0]    bus_addr,
  input  logic          bus_wr,
  input  logic          bus_rd,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  output logic          dma_req,
  input  logic          dma_ack_n,
  output logic [DW-1:0] dma_data,
  output logic          proto_err
);
  localparam int CNT_W = $clog2(MAX_BYTES + 1);
  localparam int LAST  = MAX_BYTES - 1;

  phase_t           phase_q;
  logic             gap_q, err_q, ex_dma_q;
  logic [CNT_W-1:0] idx_q;
  logic [DW-1:0]    opc_q, pcn_q;
  logic [DW-1:0]    prm_q [1:LAST];
  logic [DLY_W-1:0] dly_q;

  logic [DW-1:0]    tbl_opc;
  logic [CNT_W-1:0] n_bytes, n_res, idx_nx;
  logic             dma_cmd;
  logic             data_sel, host_side, wr_ok, wr_bad, rd_ok, last_byte;
  logic             dma_go, dma_done, stub_start, stub_done;
  logic [DW-1:0]    msr, res_byte;

  assign tbl_opc = (phase_q == PH_IDLE) ? bus_wdata : opc_q;

  dsk_cmd_table #(.CNT_W(CNT_W)) u_tbl (
    .opc(tbl_opc), .n_bytes(n_bytes), .n_res(n_res), .dma_cmd(dma_cmd));

  assign data_sel  = (bus_addr == ADDR_DATA);
  assign host_side = (phase_q == PH_IDLE) || (phase_q == PH_CMD);
  assign wr_ok     = bus_wr && data_sel && host_side && !gap_q;
  assign wr_bad    = bus_wr && data_sel && !wr_ok;
  assign rd_ok     = bus_rd && data_sel && (phase_q == PH_RES) && !gap_q;
  assign idx_nx    = idx_q + CNT_W'(1);
  assign last_byte = wr_ok && ((phase_q == PH_IDLE) ? (n_bytes == CNT_W'(1))
                                                   : (idx_nx == n_bytes));
  assign dma_go     = (phase_q == PH_EXEC) && ex_dma_q;
  assign stub_start = (last_byte && !(dma_cmd && bus_wdata != '0)) || dma_done;

  dsk_dma_engine #(.LEN_W(DW)) u_dma (
    .clk(clk), .rst_n(rst_n), .go(dma_go), .len(prm_q[LAST]),
    .dma_ack_n(dma_ack_n), .dma_req(dma_req), .dma_data(dma_data),
    .done(dma_done));

  dsk_drive_stub #(.DLY_W(DLY_W)) u_stub (
    .clk(clk), .rst_n(rst_n), .start(stub_start), .dly(dly_q),
    .done(stub_done));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q  <= PH_IDLE;
      gap_q    <= 1'b0;
      err_q    <= 1'b0;
      ex_dma_q <= 1'b0;
      idx_q    <= '0;
      opc_q    <= '0;
      pcn_q    <= '0;
      dly_q    <= DLY_W'(DEF_DELAY);
      for (int i = 1; i <= LAST; i++) prm_q[i] <= '0;
    end else begin
      gap_q <= wr_ok || rd_ok;
      err_q <= err_q || wr_bad;
      if (dma_done) ex_dma_q <= 1'b0;
      unique case (phase_q)
        PH_IDLE: if (wr_ok) begin
          opc_q   <= bus_wdata;
          idx_q   <= CNT_W'(1);
          phase_q <= last_byte ? PH_EXEC : PH_CMD;
        end
        PH_CMD: if (wr_ok) begin
          prm_q[idx_q] <= bus_wdata;
          idx_q        <= idx_nx;
          if (opc_q == OP_SET_TIMING && idx_q == CNT_W'(1))
            dly_q <= DLY_W'(bus_wdata);
          if (last_byte) begin
            phase_q  <= PH_EXEC;
            ex_dma_q <= dma_cmd && (bus_wdata != '0);
            if (opc_q == OP_READ) pcn_q <= prm_q[2];
          end
        end
        PH_EXEC: if (stub_done) begin
          idx_q   <= '0;
          phase_q <= (n_res != '0) ? PH_RES : PH_IDLE;
        end
        PH_RES: if (rd_ok) begin
          if (idx_nx == n_res) begin
            idx_q   <= '0;
            phase_q <= PH_IDLE;
          end else begin
            idx_q <= idx_nx;
          end
        end
        default: phase_q <= PH_IDLE;
      endcase
    end
  end

  always_comb begin
    unique case (opc_q)
      OP_INT_STATUS: res_byte = (idx_q == '0) ? INT_ST0 : pcn_q;
      OP_READ: begin
        if (idx_q == '0)                   res_byte = {5'b0, prm_q[1][2:0]};
        else if (idx_q < CNT_W'(3))        res_byte = '0;
        else                               res_byte = prm_q[idx_q - CNT_W'(1)];
      end
      default: res_byte = RES_BAD_OP;
    endcase
  end

  always_comb begin
    msr           = '0;
    msr[MSR_RDY]  = !gap_q && (phase_q != PH_EXEC);
    msr[MSR_DIR]  = (phase_q == PH_RES);
    msr[MSR_NDMA] = (phase_q == PH_EXEC) && !dma_cmd;
    msr[MSR_BUSY] = (phase_q != PH_IDLE);
  end

  always_comb begin
    if (bus_addr == ADDR_STATUS)                  bus_rdata = msr;
    else if (data_sel && phase_q == PH_RES && !gap_q) bus_rdata = res_byte;
    else                                          bus_rdata = '0;
  end

  assign proto_err = err_q;

  // R2: phase ordering
  assert_idle_next_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_IDLE) |=> (phase_q != PH_RES));
  assert_exec_next_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_EXEC) |=> (phase_q != PH_CMD));
  assert_res_next_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_RES) |=> (phase_q inside {PH_RES, PH_IDLE}));
  // R3: ready drops after each accepted byte
  assert_gap_after_byte_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ok || rd_ok) |=> !msr[MSR_RDY]);
  // R9: no request outside execution
  assert_req_in_exec_R9: assert property (@(posedge clk) disable iff (!rst_n)
    dma_req |-> (phase_q == PH_EXEC));
  // R10: error flag is sticky
  assert_err_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    proto_err |=> proto_err);
endmodule

// File: tb/tb_dsk_host_seq.sv
`timescale 1ns/100ps
module tb_dsk_host_seq;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] bus_addr = 3'd4;
  logic       bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       dma_req;
  logic       dma_ack_n = 1'b1;
  logic [7:0] dma_data;
  logic       proto_err;

  int checks = 0, errors = 0;
  int exp_dly = 4;
  logic [7:0] exp_pcn = 8'h00;
  bit exp_err = 1'b0;
  int dma_seen = 0;
  int dma_wait = 0;

  always #2.5 clk = ~clk;

  dsk_host_seq dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .dma_req(dma_req), .dma_ack_n(dma_ack_n), .dma_data(dma_data),
    .proto_err(proto_err));

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_res(input logic [8:0][7:0] c, input int k,
                                         input logic [7:0] pcn);
    if (c[0] == 8'h08) return (k == 0) ? 8'h20 : pcn;
    if (c[0] == 8'h06) begin
      if (k == 0) return {5'b0, c[1][2:0]};
      if (k < 3) return 8'h00;
      return c[k-1];
    end
    return 8'h80;
  endfunction

  function automatic int n_bytes_of(input logic [7:0] op);
    return (op == 8'h03) ? 3 : (op == 8'h06) ? 9 : 1;
  endfunction
  function automatic int n_res_of(input logic [7:0] op);
    return (op == 8'h03) ? 0 : (op == 8'h08) ? 2 : (op == 8'h06) ? 7 : 1;
  endfunction

  // DMA responder: random acknowledge latency, checks byte order (R9)
  initial begin
    forever begin
      @(negedge clk);
      if (!dma_ack_n) begin
        dma_ack_n = 1'b1;
        chk("R9 req low after ack", int'(dma_req), 0);
      end else if (dma_req) begin
        if (dma_wait > 0) dma_wait--;
        else begin
          chk("R9 dma byte order", int'(dma_data), dma_seen);
          dma_seen++;
          dma_ack_n = 1'b0;
          dma_wait = int'($urandom % 3);
        end
      end
    end
  end

  task automatic sample_msr(output logic [7:0] m);
    @(negedge clk);
    bus_wr = 1'b0; bus_rd = 1'b0; bus_addr = 3'd4;
    #1 m = bus_rdata;
  endtask

  task automatic poll_ready(input bit dir);
    logic [7:0] m;
    for (int n = 0; n < 3000; n++) begin
      sample_msr(m);
      if (m[7] && m[6] == dir) return;
    end
    chk("R3 ready timeout", 0, 1);
  endtask

  task automatic wr_byte(input logic [7:0] b, output logic [7:0] m_after);
    poll_ready(1'b0);
    bus_addr = 3'd5; bus_wdata = b; bus_wr = 1'b1;
    sample_msr(m_after);
    chk("R3 ready low after write", int'(m_after[7]), 0);
  endtask

  task automatic run_cmd(input logic [8:0][7:0] c, input bit bad_exec,
                         input bit bad_res, input bit gap_probe);
    logic [7:0] m, r;
    int nb, nr, ndma, it;
    nb = n_bytes_of(c[0]);
    nr = n_res_of(c[0]);
    dma_seen = 0;
    for (int i = 0; i < nb; i++) begin
      wr_byte(c[i], m);
      if (c[0] == 8'h03 && i == 1) exp_dly = int'(c[1]);
      if (i < nb - 1) chk("R3 command dir/busy", int'(m[6:4]), 3'b001);
      if (gap_probe && i == 1 && i != nb - 1) begin
        bus_addr = 3'd5; bus_wdata = 8'hEE; bus_wr = 1'b1;  // not-ready write
        exp_err = 1'b1;
      end
    end
    if (c[0] == 8'h06) exp_pcn = c[2];
    ndma = int'(m[5]);
    it = 0;
    forever begin
      sample_msr(m);
      if (m[7]) break;
      ndma += int'(m[5]);
      it++;
      if (bad_exec && it == 1) begin
        bus_addr = 3'd5; bus_wdata = 8'h5A; bus_wr = 1'b1;
        exp_err = 1'b1;
      end else if (bad_exec && it == 2) begin
        bus_addr = 3'd5; bus_rd = 1'b1;
        #1 chk("R11 data read in exec", int'(bus_rdata), 0);
      end
      if (it > 3000) begin chk("R2 exec timeout", 0, 1); break; end
    end
    if (c[0] == 8'h06) begin
      chk("R8 no-dma bit for read", ndma, 0);
      chk("R9 dma byte count", dma_seen, int'(c[8]));
    end else begin
      chk("R8 exec length", ndma, exp_dly + 1);
    end
    if (nr == 0) begin
      chk("R7 status after no-result cmd", int'(m), 8'h80);
    end else begin
      chk("R2 status at result open", int'(m), 8'hD0);
      if (bad_res) begin
        bus_addr = 3'd5; bus_wdata = 8'hA5; bus_wr = 1'b1;
        exp_err = 1'b1;
      end
      for (int k = 0; k < nr; k++) begin
        poll_ready(1'b1);
        bus_addr = 3'd5; bus_rd = 1'b1;
        #1 r = bus_rdata;
        chk($sformatf("R5 R4 R6 result %0d of op %0h", k, c[0]), int'(r),
            int'(exp_res(c, k, exp_pcn)));
        sample_msr(m);
        chk("R3 ready low after read", int'(m[7]), 0);
      end
      sample_msr(m);
      chk("R4 status after last result", int'(m), 8'h80);
    end
    chk("R10 error flag", int'(proto_err), int'(exp_err));
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : main
    logic [8:0][7:0] c;
    logic [7:0] m;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    sample_msr(m);
    chk("R1 status after reset", int'(m), 8'h80);
    chk("R1 dma_req after reset", int'(dma_req), 0);
    chk("R1 proto_err after reset", int'(proto_err), 0);

    // R11: data read while idle
    @(negedge clk); bus_addr = 3'd5; bus_rd = 1'b1;
    #1 chk("R11 data read in idle", int'(bus_rdata), 0);
    sample_msr(m);
    chk("R11 no state change", int'(m), 8'h80);

    c = '0; c[0] = 8'h08; run_cmd(c, 0, 0, 0);                     // R8 default delay
    c = '0; c[0] = 8'h03; c[1] = 8'h00; c[2] = 8'h11; run_cmd(c, 0, 0, 0); // R7
    c = '0; c[0] = 8'h06; c[1] = 8'h05; c[2] = 8'h12; c[3] = 8'h01;
    c[4] = 8'h07; c[5] = 8'h02; c[8] = 8'h00; run_cmd(c, 0, 0, 0);   // R9 length 0
    c[8] = 8'h03; c[2] = 8'h2C; run_cmd(c, 1, 1, 0);                 // R9 R10 R11
    c = '0; c[0] = 8'h08; run_cmd(c, 0, 0, 0);                       // R5 cylinder
    c = '0; c[0] = 8'hFF; run_cmd(c, 0, 0, 0);                       // R6
    c = '0; c[0] = 8'h06; c[1] = 8'h02; c[2] = 8'h33; c[3] = 8'h44;
    c[4] = 8'h55; c[5] = 8'h66; c[8] = 8'h02; run_cmd(c, 0, 0, 1);   // R10 gap write

    for (int n = 0; n < 40; n++) begin
      int sel;
      sel = int'($urandom % 4);
      c = '0;
      for (int b = 1; b < 9; b++) c[b] = 8'($urandom);
      case (sel)
        0: begin c[0] = 8'h03; c[1] = 8'($urandom % 6); end
        1: c[0] = 8'h08;
        2: begin c[0] = 8'h06; c[8] = 8'($urandom % 6); end
        default: begin
          c[0] = 8'($urandom);
          if (c[0] inside {8'h03, 8'h06, 8'h08}) c[0] = 8'h1F;
        end
      endcase
      run_cmd(c, (sel == 2) && ($urandom % 3 == 0),
              (sel != 0) && ($urandom % 4 == 0), (sel == 2) && ($urandom % 4 == 0));
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule